// File: doc/BRIEF.md
# Replayable Word Queue with Occupancy Flags

This block is a first-in first-out store for 9-bit words, where a word is typically a byte plus a parity or framing bit. A producer pushes words by pulling its write strobe low for a cycle. A consumer pulls words out by pulling its read strobe low. The storage addresses are generated inside the block, so neither side supplies an address. Three status outputs report how full the store is: empty, more than half full, and completely full. Both sides can use these to avoid losing data.

A rewind control moves the read position back to physical slot zero and leaves the write position where it is. The block of words between slot zero and the current write position can then be read out again, as many times as needed. A rewind is only meaningful while neither position has wrapped past slot zero since reset. A single clock samples the active-low strobes once per cycle in place of free-running asynchronous strobes. The capacity is 2^AW words, so AW=13 gives 8192 words.

Top module: `fifo_rt`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, empty=1, full=0, half_full=0 and dout=0. The read position, write position and stored word count are all cleared.
- R2: A sampled low on wr_n stores din, and a sampled low on rd_n presents the oldest stored word on dout in the cycle after the edge. Words leave in the order they entered.
- R3: empty is high exactly when the stored word count is zero.
- R4: full is high exactly when the stored word count equals 2^AW.
- R5: half_full is high exactly when the stored word count exceeds 2^(AW-1).
- R6: A write request while full is ignored. The count and the stored data do not change.
- R7: A read request while empty is ignored, and dout keeps its previous value.
- R8: A read and a write in the same cycle, while neither full nor empty, leave the count unchanged. Both positions advance.
- R9: A sampled low on rt_n sets the read position to slot zero and leaves the write position unchanged. The count becomes the write position, plus one if a write is accepted in that same cycle. A read request in that cycle is ignored.
- R10: All flags are registered functions of the count. They change in the cycle after the edge that accepted the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Rewind read position to slot zero, active low |
| din | input | DW | Word to store |
| dout | output | DW | Last word read |
| full | output | 1 | Store holds 2^AW words |
| half_full | output | 1 | Store holds more than half its capacity |
| empty | output | 1 | Store holds no words |

## Verification
The bench uses an 8-word configuration. It steps the flags through every count from zero to full and back. A design whose thresholds are off by one shows a half-full or full flag one word early or late. Writes are pushed at a full store and reads at an empty one. A design that does not block these overwrites the oldest word or shifts dout, and the data read back later differs. Rewinds are replayed twice, including one that coincides with a write. A design that clears the write position, or recomputes the count wrongly, returns a short or shifted block. A long pseudo-random mix of simultaneous reads and writes with wrapping positions exposes count drift.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          half_full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  wire do_wr = !wr_n && !full;
  wire do_rd = !rd_n && !empty && rt_n;

  assign empty     = (count == '0);
  assign full      = (count == CNT_FULL);
  assign half_full = (count > CNT_HALF);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (!rt_n) begin
        rptr  <= '0;
        count <= {1'b0, wptr} + (AW+1)'(do_wr);
      end else begin
        if (do_rd) begin
          rptr <= rptr + 1'b1;
          dout <= mem[rptr];
        end
        count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
      end
    end
  end
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic [DW-1:0] dout,
  input logic          full,
  input logic          half_full,
  input logic          empty,
  input logic [AW:0]   count,
  input logic [AW-1:0] rptr,
  input logic [AW-1:0] wptr
);
  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  // R5
  half_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) half_full |-> !empty);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && rt_n) |=> (full && $stable(count) && $stable(wptr)));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_n && rt_n) |=> $stable(dout));
  // R8
  rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && !wr_n && !rd_n && rt_n) |=> $stable(count));
  // R9
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && wr_n) |=> (rptr == '0 && $stable(wptr)));
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (count == (AW+1)'(1 << AW)));
endmodule

bind fifo_rt fifo_rt_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .dout(dout), .full(full), .half_full(half_full), .empty(empty),
  .count(count), .rptr(rptr), .wptr(wptr)
);

// File: tb/fifo_rt_tb.sv
module fifo_rt_tb;
  localparam int DW = 9;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, wr_n, rd_n, rt_n;
  logic [DW-1:0] din, dout;
  logic full, half_full, empty;

  int vecs = 0, errs = 0;
  logic [DW-1:0] m_mem [DEPTH];
  int m_wp, m_rp, m_cnt;
  logic [DW-1:0] m_dout;
  logic [15:0] lfsr;

  always #2 clk = ~clk;

  fifo_rt #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .full(full), .half_full(half_full), .empty(empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 empty", 32'(empty), 32'(m_cnt == 0));
    chk("R4 full", 32'(full), 32'(m_cnt == DEPTH));
    chk("R5 half_full", 32'(half_full), 32'(m_cnt > DEPTH/2));
    chk("R2 dout", 32'(dout), 32'(m_dout));
  endtask

  // drive at negedge, model the edge, check at next negedge (R10)
  task automatic step(input logic w, input logic r, input logic t, input logic [DW-1:0] d);
    bit dw, dr;
    @(negedge clk);
    wr_n = ~w; rd_n = ~r; rt_n = ~t; din = d;
    dw = w && (m_cnt != DEPTH);
    dr = r && (m_cnt != 0) && !t;
    if (dw) m_mem[m_wp] = d;
    if (t) begin
      m_cnt = m_wp + int'(dw);
      m_rp = 0;
    end else begin
      if (dr) begin m_dout = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
      m_cnt = m_cnt + int'(dw) - int'(dr);
    end
    if (dw) m_wp = (m_wp + 1) % DEPTH;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_wp = 0; m_rp = 0; m_cnt = 0; m_dout = '0;
    @(negedge clk);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 half_full", 32'(half_full), 32'd0);
    chk("R1 dout", 32'(dout), 32'd0);
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    do_reset();
    // R3 R4 R5: sweep count up to full, then one blocked write (R6)
    for (int i = 0; i <= DEPTH; i++) step(1, 0, 0, DW'(9'h100 | i));
    chk("R6 full held", 32'(full), 32'd1);
    // drain, then reads on empty keep dout (R7)
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, '0);
    chk("R2 last word", 32'(dout), 32'(9'h100 | (DEPTH-1)));
    step(0, 1, 0, '0);
    step(0, 1, 0, '0);
    chk("R7 dout held", 32'(dout), 32'(9'h100 | (DEPTH-1)));
    // R8: simultaneous read/write at mid occupancy
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 0, 0, DW'(i + 9'h020));
    for (int i = 0; i < 10; i++) step(1, 1, 0, DW'(i + 9'h040));
    // R9: rewind replay
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 0, 0, DW'(9'h0A0 + i));
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0);
    step(0, 1, 1, '0);
    chk("R9 count after rewind", 32'(half_full), 32'd1);
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0, '0);
      chk("R9 replay word", 32'(dout), 32'(9'h0A0 + i));
    end
    step(1, 0, 1, 9'h0A5);
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0, '0);
      chk("R9 replay with write", 32'(dout), 32'(9'h0A0 + i));
    end
    // mixed pseudo-random traffic with wrap (R2 R8)
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | (lfsr[5] & lfsr[7]), 0, DW'(lfsr[11:3]));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule